// File: doc/BRIEF.md
# Flash Reset and Busy Sequencer

This block sits between the hardware reset pin of a NOR-style flash memory model and the model's data bus and command decoder. It passes the active-low reset pin through a two-stage synchroniser. It then checks that the low pulse lasts a minimum number of cycles before it treats the pulse as a real reset, so a short glitch changes nothing. A qualified reset raises a one-cycle pulse that aborts any embedded program or erase and sends the command state machine back to array-read mode. While the reset lasts, the block keeps the data outputs disabled and ignores every command.

After the pin is released, the block holds off reads and commands until two conditions are both met. The first is an internal recovery interval, which is long if an embedded operation was running when the reset qualified and short otherwise. The second is a settling window counted from the release. The ready/busy line stays low across the long recovery. During the short one it stays high. A command that arrives after the release but before access reopens is dropped and flagged on a rejection output. A sticky flag records that an operation was cut off, and the next accepted command clears it.

Top module: `flash_reset_seq`

## Requirements
- R1: A reset pin low pulse that is sampled low on fewer than `TRP_CYC` consecutive clock edges has no effect: `abort_home` stays 0, `ry_by_n` follows `op_running`, and commands stay accepted.
- R2: A low pulse of at least `TRP_CYC` sampled edges produces exactly one `abort_home` pulse. Counting the first edge that samples the pin low as edge 0, this pulse is high in the cycle after edge `TRP_CYC+2`.
- R3: From the `abort_home` pulse until access reopens, `dout_en` and `cmd_accept` are 0.
- R4: If `op_running` was 1 when the reset qualified, `ry_by_n` is 0 for the `TRDY_BUSY_CYC` cycles that begin with the `abort_home` cycle, and 1 afterwards.
- R5: If `op_running` was 0 when the reset qualified, `ry_by_n` stays 1 throughout. The recovery interval is then `TRDY_IDLE_CYC` cycles.
- R6: Take the pin as sampled low on edges 0 to L-1, and define E = `TRP_CYC`+2, X = 2+max(L, `TRP_CYC`+1), and R = the applicable recovery interval. Access reopens (`dout_en`, `cmd_accept`) after edge max(X+`TRH_CYC`, E+R)+1.
- R7: `cmd_reject` is 1 in exactly those cycles in which a read or write strobe arrives after the synchronised release and before access reopens. It is 0 during the reset pulse itself and in normal operation.
- R8: `abort_flag` is set from the cycle after `abort_home` if `op_running` was 1 when the reset qualified. It stays set until the cycle after the first accepted command.
- R9: In normal operation `dout_en` is 1 exactly when `oe_n` is 0.
- R10: A synchronous `srst` returns the block to normal operation with `abort_flag` clear, whatever phase it was in.
- R11: In normal operation `ry_by_n` is the inverse of `op_running`, and any read or write strobe raises `cmd_accept` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset of the block |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset pin |
| op_running | input | 1 | Embedded program or erase in progress |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| oe_n | input | 1 | Active-low output enable from the host |
| ry_by_n | output | 1 | Ready (1) / busy (0) |
| dout_en | output | 1 | Data bus drive enable |
| cmd_accept | output | 1 | Command strobe accepted this cycle |
| cmd_reject | output | 1 | Command strobe dropped during recovery |
| abort_home | output | 1 | One-cycle pulse: abort operation, command state machine to array read |
| abort_flag | output | 1 | Sticky: an operation was aborted by reset |

## Verification
The assertions assume that `op_running` is a level from the operation engine that falls only after `abort_home`. They also assume that `srst` is never raised in the two cycles before an assertion needs history. The bench therefore drops `op_running` in the cycle after the abort pulse and only pulses `srst` while the reset pin is high. All stimulus changes on the falling clock edge. The reset pin is held low for whole cycles, so the number of sampled low edges, and with it every expected phase boundary, follows exactly from the pulse length. The sweep covers every pulse length from one edge to three past the minimum, for both an idle and a busy engine, and alternates read and write strobes.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

    typedef enum logic [1:0] {
        PH_ARRAY_RD = 2'd0,
        PH_HELD     = 2'd1,
        PH_SETTLE   = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t phase;
        logic   was_busy;
        logic   rdy_done;
        logic   rh_done;
        logic   entry;
    } recov_stat_t;

    function automatic int frs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic srst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (srst) chain <= RST_VAL;
                else      chain <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (srst) chain <= {STAGES{RST_VAL}};
                else      chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/frs_pulse_qual.sv
module frs_pulse_qual #(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic srst,
    input  logic low_i,
    output logic held_o
);
    localparam int QW = $clog2(MIN_W + 1);

    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (srst)        cnt <= '0;
        else if (!low_i) cnt <= '0;
        else if (cnt != QW'(MIN_W)) cnt <= cnt + 1'b1;
    end

    assign held_o = (cnt == QW'(MIN_W));

    // R1
    held_needs_low_chk: assert property (@(posedge clk) disable iff (srst)
        held_o |-> $past(low_i));
endmodule

// File: rtl/frs_recovery.sv
module frs_recovery
    import flash_rst_pkg::*;
#(
    parameter int TRDY_BUSY = 40,
    parameter int TRDY_IDLE = 8,
    parameter int TRH       = 3
) (
    input  logic        clk,
    input  logic        srst,
    input  logic        held_i,
    input  logic        pin_low_i,
    input  logic        op_running_i,
    output recov_stat_t stat_o
);
    localparam int RLIM = frs_max(TRDY_BUSY, TRDY_IDLE);
    localparam int RW   = $clog2(RLIM + 1);
    localparam int HW   = $clog2(TRH + 1);

    phase_t        phase;
    logic          was_busy;
    logic          entry_q;
    logic [RW-1:0] rdy_cnt;
    logic [HW-1:0] rh_cnt;
    logic [RW-1:0] lim;
    logic          rdy_done;
    logic          rh_done;
    logic [RW-1:0] rdy_next;
    logic [HW-1:0] rh_next;

    always_comb begin
        lim      = was_busy ? RW'(TRDY_BUSY) : RW'(TRDY_IDLE);
        rdy_done = (rdy_cnt >= lim);
        rh_done  = (rh_cnt == HW'(TRH));
        rdy_next = rdy_done ? rdy_cnt : rdy_cnt + 1'b1;
        if (pin_low_i)    rh_next = '0;
        else if (rh_done) rh_next = rh_cnt;
        else              rh_next = rh_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            phase    <= PH_ARRAY_RD;
            was_busy <= 1'b0;
            entry_q  <= 1'b0;
            rdy_cnt  <= '0;
            rh_cnt   <= '0;
        end else begin
            entry_q <= 1'b0;
            unique case (phase)
                PH_ARRAY_RD: begin
                    if (held_i) begin
                        phase    <= PH_HELD;
                        was_busy <= op_running_i;
                        rdy_cnt  <= '0;
                        entry_q  <= 1'b1;
                    end
                end
                PH_HELD: begin
                    rdy_cnt <= rdy_next;
                    if (!pin_low_i) begin
                        phase  <= PH_SETTLE;
                        rh_cnt <= '0;
                    end
                end
                PH_SETTLE: begin
                    if (held_i) begin
                        phase    <= PH_HELD;
                        was_busy <= op_running_i | (was_busy & ~rdy_done);
                        rdy_cnt  <= '0;
                        entry_q  <= 1'b1;
                    end else begin
                        rdy_cnt <= rdy_next;
                        rh_cnt  <= rh_next;
                        if (rh_done && rdy_done && !pin_low_i)
                            phase <= PH_ARRAY_RD;
                    end
                end
                default: phase <= PH_ARRAY_RD;
            endcase
        end
    end

    assign stat_o = '{phase: phase, was_busy: was_busy, rdy_done: rdy_done,
                      rh_done: rh_done, entry: entry_q};

    // R6
    exit_ready_chk: assert property (@(posedge clk) disable iff (srst)
        (phase == PH_ARRAY_RD && $past(phase) == PH_SETTLE && !$past(srst))
            |-> $past(rdy_done && rh_done));
endmodule

// File: rtl/flash_reset_seq.sv
module flash_reset_seq
    import flash_rst_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int TRP_CYC       = 4,
    parameter int TRDY_BUSY_CYC = 40,
    parameter int TRDY_IDLE_CYC = 8,
    parameter int TRH_CYC       = 3
) (
    input  logic clk,
    input  logic srst,
    input  logic rst_pin_n,
    input  logic op_running,
    input  logic cmd_rd,
    input  logic cmd_wr,
    input  logic oe_n,
    output logic ry_by_n,
    output logic dout_en,
    output logic cmd_accept,
    output logic cmd_reject,
    output logic abort_home,
    output logic abort_flag
);
    logic        pin_s;
    logic        pin_low;
    logic        q_held;
    logic        strobe;
    logic        normal;
    recov_stat_t st;

    frs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .srst (srst),
        .d_i  (rst_pin_n),
        .q_o  (pin_s)
    );

    assign pin_low = ~pin_s;

    frs_pulse_qual #(.MIN_W(TRP_CYC)) u_qual (
        .clk    (clk),
        .srst   (srst),
        .low_i  (pin_low),
        .held_o (q_held)
    );

    frs_recovery #(
        .TRDY_BUSY (TRDY_BUSY_CYC),
        .TRDY_IDLE (TRDY_IDLE_CYC),
        .TRH       (TRH_CYC)
    ) u_recov (
        .clk          (clk),
        .srst         (srst),
        .held_i       (q_held),
        .pin_low_i    (pin_low),
        .op_running_i (op_running),
        .stat_o       (st)
    );

    always_comb begin
        normal     = (st.phase == PH_ARRAY_RD);
        strobe     = cmd_rd | cmd_wr;
        cmd_accept = normal & strobe;
        cmd_reject = (st.phase == PH_SETTLE) & strobe;
        dout_en    = normal & ~oe_n;
        abort_home = st.entry;
        if (normal) ry_by_n = ~op_running;
        else        ry_by_n = ~(st.was_busy & ~st.rdy_done);
    end

    always_ff @(posedge clk) begin
        if (srst)                        abort_flag <= 1'b0;
        else if (st.entry & st.was_busy) abort_flag <= 1'b1;
        else if (cmd_accept)             abort_flag <= 1'b0;
    end

    // R2
    abort_src_chk: assert property (@(posedge clk) disable iff (srst)
        abort_home |-> $past(q_held));

    // R8
    flag_src_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(abort_flag) |-> $past(op_running, 2));

    // R3
    no_drive_after_abort_chk: assert property (@(posedge clk) disable iff (srst)
        $past(abort_home) |-> !dout_en && !cmd_accept);

    // R7
    reject_excl_chk: assert property (@(posedge clk) disable iff (srst)
        cmd_reject |-> !cmd_accept && !abort_home);
endmodule

// File: tb/flash_reset_seq_test.sv
`timescale 1ns/1ps
module flash_reset_seq_test;
    localparam int TRP = 4;
    localparam int TL  = 40;
    localparam int TS  = 8;
    localparam int TRH = 3;

    logic clk = 1'b0;
    logic srst, rst_pin_n, op_running, cmd_rd, cmd_wr, oe_n;
    logic ry_by_n, dout_en, cmd_accept, cmd_reject, abort_home, abort_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_reset_seq #(
        .SYNC_STAGES(2), .TRP_CYC(TRP), .TRDY_BUSY_CYC(TL),
        .TRDY_IDLE_CYC(TS), .TRH_CYC(TRH)
    ) uut (
        .clk(clk), .srst(srst), .rst_pin_n(rst_pin_n), .op_running(op_running),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .oe_n(oe_n),
        .ry_by_n(ry_by_n), .dout_en(dout_en), .cmd_accept(cmd_accept),
        .cmd_reject(cmd_reject), .abort_home(abort_home), .abort_flag(abort_flag)
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) @(negedge clk);
    endtask

    // One reset pulse of len sampled edges with the engine state op0
    task automatic run_pulse(input int op0, input int len);
        bit valid;
        int e, x, n, lim, imax, ph;
        logic use_wr, e_ry, e_fl;
        string rq;
        valid  = (len >= TRP);
        use_wr = logic'(len % 2);
        e      = TRP + 2;
        x      = 2 + mx(len, TRP + 1);
        lim    = op0 ? TL : TS;
        n      = mx(x + TRH, e + lim) + 1;
        imax   = valid ? n + 3 : len + 6;
        @(negedge clk);
        op_running = logic'(op0);
        cmd_rd = ~use_wr;
        cmd_wr = use_wr;
        oe_n = 1'b0;
        rst_pin_n = 1'b0;
        for (int i = 0; i <= imax; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (!valid) begin
                chk("R1", "abort_home", abort_home, 1'b0);
                chk("R1", "ry_by_n", ry_by_n, logic'(op0 == 0));
                chk("R1", "cmd_accept", cmd_accept, 1'b1);
                chk("R1", "dout_en", dout_en, 1'b1);
                chk("R1", "cmd_reject", cmd_reject, 1'b0);
                chk("R1", "abort_flag", abort_flag, 1'b0);
            end else begin
                if (i < e) ph = 0;
                else if (i < x) ph = 1;
                else if (i < n) ph = 2;
                else ph = 0;
                chk("R2", "abort_home", abort_home, logic'(i == e));
                rq = (i >= n) ? "R6" : "R3";
                chk(rq, "dout_en", dout_en, logic'(ph == 0));
                chk(rq, "cmd_accept", cmd_accept, logic'(ph == 0));
                chk("R7", "cmd_reject", cmd_reject, logic'(ph == 2));
                if (ph == 0) e_ry = (i < e) ? logic'(op0 == 0) : 1'b1;
                else         e_ry = ~logic'(op0 != 0 && (i - e) < TL);
                chk(op0 ? "R4" : "R5", "ry_by_n", ry_by_n, e_ry);
                e_fl = logic'(op0 != 0 && i >= e + 1 && i <= n);
                chk("R8", "abort_flag", abort_flag, e_fl);
            end
            if (i == len - 1) rst_pin_n = 1'b1;
            if (valid && i == e) op_running = 1'b0;
        end
        cmd_rd = 1'b0;
        cmd_wr = 1'b0;
        op_running = 1'b0;
        idle(3);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        srst = 1'b1; rst_pin_n = 1'b1; op_running = 1'b0;
        cmd_rd = 1'b0; cmd_wr = 1'b0; oe_n = 1'b0;
        idle(3);
        srst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10", "ry_by_n", ry_by_n, 1'b1);
        chk("R10", "dout_en", dout_en, 1'b1);
        chk("R10", "cmd_accept", cmd_accept, 1'b0);
        chk("R10", "abort_home", abort_home, 1'b0);
        chk("R10", "abort_flag", abort_flag, 1'b0);

        // R9 and R11: output enable and busy follow inputs in normal operation
        for (int k = 0; k < 8; k++) begin
            oe_n = logic'(k[0]);
            op_running = logic'(k[1]);
            cmd_rd = logic'(k[2]);
            cmd_wr = logic'(k[2] & k[0]);
            #1;
            chk("R9", "dout_en", dout_en, ~oe_n);
            chk("R11", "ry_by_n", ry_by_n, ~op_running);
            chk("R11", "cmd_accept", cmd_accept, cmd_rd | cmd_wr);
            @(negedge clk);
        end
        oe_n = 1'b0; op_running = 1'b0; cmd_rd = 1'b0; cmd_wr = 1'b0;
        idle(2);

        // Sweep pulse lengths and engine state
        for (int op0 = 0; op0 < 2; op0++)
            for (int len = 1; len <= TRP + 3; len++)
                run_pulse(op0, len);

        // R9 during recovery output stays off even with oe_n low
        op_running = 1'b1;
        rst_pin_n = 1'b0;
        idle(TRP + 4);
        op_running = 1'b0;
        oe_n = 1'b0;
        chk("R9", "dout_en in reset", dout_en, 1'b0);
        // R10 srst mid-reset with pin released
        rst_pin_n = 1'b1;
        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        @(negedge clk);
        chk("R10", "dout_en", dout_en, 1'b1);
        chk("R10", "abort_flag", abort_flag, 1'b0);
        chk("R10", "ry_by_n", ry_by_n, 1'b1);
        oe_n = 1'b1;
        #1;
        chk("R9", "dout_en oe_n high", dout_en, 1'b0);
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule